// File: doc/BRIEF.md
# Switch-Clamped Cell Gate Decoder with Capacitor Balancing

This block sits between a single-carrier multilevel template generator and the gate drivers of a chain of N cascaded five-switch clamped H-bridge cells. Each carrier period it takes the template level and the sign of the fundamental half-cycle. From these it produces five gate signals per cell, so that the chain's output steps add up to the template level. Each cell contributes nothing, a half step (one capacitor half) or a full step (both halves) of its dc link.

Which cells conduct is decided from the measured voltages of all 2N capacitor halves. In the positive half-cycle, cells whose lowest half is least charged are served first. In the negative half-cycle, cells whose highest half is most charged are served first. This spreads switching activity across the chain and pulls the capacitor voltages toward each other. The second leg of every cell runs as a fundamental-rate square wave set by the sign input. Each cell's gate vector is the OR of a positive-half vector and a negative-half vector. Only the vector for the active half-cycle is non-zero.

The gate outputs are registered and are updated only on the carrier-period strobe.

Top module: `scc_gate_decoder`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, every cell's 5-bit gate group holds 01010. Cell c occupies `gates[5c+4:5c]`, ordered g1 (bit 4) down to g5 (bit 0).
- R2: The gate outputs change only on a rising clock edge at which `strobe` is 1. On all other edges they hold.
- R3: In the positive half-cycle (`positive`=1), a cell given zero, a half step or a full step shows 01010, 01001 or 11000 respectively.
- R4: In the negative half-cycle (`positive`=0), a cell given zero, a half step or a full step shows 10100, 00101 or 00110 respectively.
- R5: In every cycle out of reset, exactly two of each cell's five gates are 1.
- R6: Counting a half step as 1 and a full step as 2, the sum over all cells equals the sampled `level`. A `level` above 2N is treated as 2N.
- R7: Capacitor half k is the 12-bit field `cap_v[12k+11:12k]`; halves 2c and 2c+1 belong to cell c. In the positive half-cycle, cells are prioritised by the position of their lower-voltage half in an ascending sort of all halves. Equal voltages rank the lower half index first.
- R8: In the negative half-cycle, cells are prioritised by the position of their higher-voltage half in a descending sort of all halves. Equal voltages still rank the lower half index first.
- R9: With clamped level L, the floor(L/2) highest-priority cells get a full step. If L is odd, the next cell gets the half step. All remaining cells get zero.
- R10: After each strobe, every cell has g2 equal to the sampled `positive` and g3 equal to its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Carrier-period update pulse |
| positive | input | 1 | 1 in the positive fundamental half-cycle |
| level | input | LW = clog2(2N+1) | Template level, 0 to 2N |
| cap_v | input | 2N*VW | Capacitor half voltages, VW bits each |
| gates | output | 5N | Gate signals, five per cell |

## Verification
On every cycle, the assertions check four things: the two-switches-on rule per cell; that the outputs hold between strobes; that the second leg follows the sampled sign; and that the decoded steps add up to the clamped level. Whether the correct cells were chosen can only be shown by the bench scenarios. These compare the outputs against an independent sort-based model, using crafted voltage orders, all-equal ties, over-range levels and random patterns in both half-cycles.

// File: rtl/scc_gate_decoder.sv
module scc_gate_decoder #(
  parameter int N_CELLS = 3,
  parameter int VW = 12,
  localparam int LW = $clog2(2*N_CELLS+1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      strobe,
  input  logic                      positive,
  input  logic [LW-1:0]             level,
  input  logic [2*N_CELLS*VW-1:0]   cap_v,
  output logic [5*N_CELLS-1:0]      gates
);
  localparam int NH = 2*N_CELLS;

  logic [VW-1:0] v [NH];
  int            rnk [NH];
  int            crank [N_CELLS];
  int            prio [N_CELLS];
  int            lvl_c;
  logic [5*N_CELLS-1:0] nxt;

  for (genvar k = 0; k < NH; k++) begin : g_slice
    assign v[k] = cap_v[k*VW +: VW];
  end

  function automatic logic ahead(input logic [VW-1:0] va, input logic [VW-1:0] vb,
                                 input int a, input int b, input logic pos);
    if (va == vb) return a < b;
    return pos ? (va < vb) : (va > vb);
  endfunction

  function automatic logic [4:0] pattern(input int st, input logic pos);
    logic [4:0] gp, gn;
    gp = (st == 2) ? 5'b11000 : (st == 1) ? 5'b01001 : 5'b01010;
    gn = (st == 2) ? 5'b00110 : (st == 1) ? 5'b00101 : 5'b10100;
    return (pos ? gp : 5'b0) | (pos ? 5'b0 : gn);
  endfunction

  always_comb begin
    int full, st;
    for (int i = 0; i < NH; i++) begin
      rnk[i] = 0;
      for (int j = 0; j < NH; j++)
        if (j != i && ahead(v[j], v[i], j, i, positive)) rnk[i]++;
    end
    for (int c = 0; c < N_CELLS; c++)
      crank[c] = (rnk[2*c] < rnk[2*c+1]) ? rnk[2*c] : rnk[2*c+1];
    for (int c = 0; c < N_CELLS; c++) begin
      prio[c] = 0;
      for (int d = 0; d < N_CELLS; d++)
        if (crank[d] < crank[c]) prio[c]++;
    end
    lvl_c = (int'(level) > NH) ? NH : int'(level);
    full  = lvl_c / 2;
    for (int c = 0; c < N_CELLS; c++) begin
      st = (prio[c] < full) ? 2 : ((prio[c] == full) && (lvl_c % 2 == 1)) ? 1 : 0;
      nxt[5*c +: 5] = pattern(st, positive);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gates <= {N_CELLS{5'b01010}};
    else if (strobe) gates <= nxt;
  end

  int sum_out;
  always_comb begin
    sum_out = 0;
    for (int c = 0; c < N_CELLS; c++) begin
      if (gates[5*c +: 5] == 5'b11000 || gates[5*c +: 5] == 5'b00110) sum_out += 2;
      else if (gates[5*c +: 5] == 5'b01001 || gates[5*c +: 5] == 5'b00101) sum_out += 1;
    end
  end

  for (genvar c = 0; c < N_CELLS; c++) begin : g_chk
    a_r5_two_on: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gates[5*c +: 5]) == 2);
    a_r10_leg: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> (gates[5*c+3] == $past(positive)) && (gates[5*c+2] == !$past(positive)));
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(gates));
  a_r6_sum: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> sum_out == $past(lvl_c));
endmodule

// File: tb/scc_gate_decoder_tb.sv
module scc_gate_decoder_tb;
  localparam int N = 3;
  localparam int NH = 2*N;
  localparam int LW = $clog2(2*N+1);

  logic clk = 0, rst_n = 0, strobe = 0, positive = 1;
  logic [LW-1:0] level = 0;
  logic [NH*12-1:0] cap_v = 0;
  logic [5*N-1:0] gates;
  logic [5*N-1:0] exp_g;
  int errors = 0, checks = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  scc_gate_decoder #(.N_CELLS(N), .VW(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .positive(positive),
    .level(level), .cap_v(cap_v), .gates(gates));

  function automatic logic [5*N-1:0] model(input logic [NH*12-1:0] cv, input int lv, input bit pos);
    int ord[NH];
    int q[$];
    bit seen[N];
    int L, t;
    logic [5*N-1:0] r;
    for (int k = 0; k < NH; k++) ord[k] = k;
    for (int i = 1; i < NH; i++) begin
      for (int j = i; j > 0; j--) begin
        int a, b, va, vb; bit sw;
        a = ord[j]; b = ord[j-1];
        va = int'(cv[a*12 +: 12]); vb = int'(cv[b*12 +: 12]);
        sw = (va == vb) ? (a < b) : (pos ? va < vb : va > vb);
        if (sw) begin t = ord[j]; ord[j] = ord[j-1]; ord[j-1] = t; end
      end
    end
    for (int c = 0; c < N; c++) seen[c] = 0;
    for (int k = 0; k < NH; k++)
      if (!seen[ord[k]/2]) begin seen[ord[k]/2] = 1; q.push_back(ord[k]/2); end
    L = (lv > NH) ? NH : lv;
    for (int p = 0; p < N; p++) begin
      int st;
      st = (p < L/2) ? 2 : (p == L/2 && L%2 == 1) ? 1 : 0;
      if (pos) r[5*q[p] +: 5] = (st == 2) ? 5'b11000 : (st == 1) ? 5'b01001 : 5'b01010;
      else     r[5*q[p] +: 5] = (st == 2) ? 5'b00110 : (st == 1) ? 5'b00101 : 5'b10100;
    end
    return r;
  endfunction

  always @(posedge clk)
    if (!rst_n) exp_g = {N{5'b01010}};
    else if (strobe) exp_g = model(cap_v, int'(level), positive);

  task automatic check(input string t, input logic [5*N-1:0] act, input logic [5*N-1:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: gates=%b expected=%b", t, act, ex);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check(tag, gates, exp_g);
  endtask

  task automatic apply(input int c0u, c0l, c1u, c1l, c2u, c2l, input int lv, input bit pos);
    cap_v = {12'(c2l), 12'(c2u), 12'(c1l), 12'(c1u), 12'(c0l), 12'(c0u)};
    level = LW'(lv); positive = pos; strobe = 1;
    @(negedge clk);
    strobe = 0;
  endtask

  initial begin
    #(200000*8);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_g = {N{5'b01010}};
    @(negedge clk); @(negedge clk);
    check("R1 in reset", gates, {N{5'b01010}});
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", gates, {N{5'b01010}});

    // R7/R9/R3: priority c1,c2,c0; level 3 -> c1 full, c2 half
    apply(500, 600, 100, 900, 300, 200, 3, 1);
    check("R7 R9 R3 positive ranking", gates, {5'b01001, 5'b11000, 5'b01010});
    // R2: inputs change with no strobe
    cap_v = 0; level = 0; positive = 0;
    @(negedge clk); @(negedge clk);
    check("R2 hold without strobe", gates, {5'b01001, 5'b11000, 5'b01010});
    // R8/R4: priority c1,c0,c2
    apply(500, 600, 100, 900, 300, 200, 3, 0);
    check("R8 R4 negative ranking", gates, {5'b10100, 5'b00110, 5'b00101});
    // R7 ties
    apply(400, 400, 400, 400, 400, 400, 1, 1);
    check("R7 tie lower index", gates, {5'b01010, 5'b01010, 5'b01001});
    apply(400, 400, 400, 400, 400, 400, 1, 0);
    check("R8 tie lower index", gates, {5'b10100, 5'b10100, 5'b00101});
    // R6 clamp
    apply(1, 2, 3, 4, 5, 6, 7, 1);
    check("R6 clamp level 7", gates, {N{5'b11000}});
    apply(1, 2, 3, 4, 5, 6, 0, 0);
    check("R4 R10 zero negative", gates, {N{5'b10100}});
    apply(9, 8, 7, 6, 5, 4, 6, 0);
    check("R9 all full negative", gates, {N{5'b00110}});

    tag = "R9 random vs model";
    for (int i = 0; i < 600; i++) begin
      cap_v = {$urandom, $urandom, $urandom};
      if (i % 5 == 0) cap_v = {NH{12'($urandom_range(0, 3))}};
      level = LW'($urandom_range(0, 7));
      positive = 1'($urandom);
      strobe = ($urandom_range(0, 2) == 0);
      cyc();
    end
    strobe = 0;
    tag = "R5 settle";
    cyc();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule